// File: doc/BRIEF.md
# Windowed Auto-Increment Coefficient Memory Port

This block is the host-side access path to the coefficient store of a decimating FIR filter. The host sets up a tap count, a coefficient offset and a symmetric-mode bit. These settings go straight to the filter datapath. The host then opens an address window on the 64-entry, 16-bit coefficient memory by writing a stop address and then a start address. After that it moves whole coefficients through one data register. Each completed read or write of that register uses the current memory location and then steps an internal pointer by one. The last location used is the stop address.

The host bus can run in word mode or in byte mode. In byte mode each coefficient takes two transfers on bits 7:0, low byte first, and the pointer moves only after the second byte. When the window is used up, further data-register accesses do nothing and set a sticky overrun flag. Writing the start address reloads the pointer, clears the flag and drops any half-sent byte pair.

A separate read port lets the filter fetch coefficients by address. Host traffic to the memory is expected only while the filter is idle.

Top module: `coef_window_port`

## Requirements
- R1: After reset all five setting registers are 0, the pointer is 0, the stop address is 0, `ovr_flag` and `host_rvalid` are 0, and every memory word reads as 0.
- R2: The register select codes are 0 taps (7 bits), 1 offset (6 bits), 2 control (bit 0 selects symmetric mode), 3 start (6 bits), 4 stop (6 bits) and 5 data. A read of select code 0 to 4 raises `host_rvalid` in the following cycle, with the register value zero-extended on `host_rdata`.
- R3: In word mode, each write to the data register stores `host_wdata` at the pointer and then advances the pointer. The first location written is the start address and the last is the stop address.
- R4: In word mode, each read of the data register returns the word at the pointer in the following cycle and then advances the pointer over the same window.
- R5: When start equals stop, exactly one location is accessed, and the next data access is ignored.
- R6: Once the stop address has been used, data reads return 0, data writes leave the memory unchanged, and `ovr_flag` rises and stays high until the start register is written.
- R7: In byte mode, a data write first holds `host_wdata[7:0]` as the low byte. The following data write commits {its bits 7:0, held low byte} at the pointer and advances it. Memory is unchanged after the first byte.
- R8: In byte mode, the first data read returns bits 7:0 of the word at the pointer, and the second read returns bits 15:8 and then advances the pointer.
- R9: A write to the start register loads the pointer, clears `ovr_flag` and discards any held low byte.
- R10: `flt_rdata` returns the memory word at `flt_raddr` one cycle later. `flt_taps`, `flt_offset` and `flt_sym` follow their registers and change only when their own register is written.
- R11: `flt_cfg_ok` is 0 exactly when symmetric mode is off and the taps register exceeds 63; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | 1: coefficients move as two byte transfers |
| host_wr | input | 1 | Host write strobe; wins over a read in the same cycle |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 3 | Register select code |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid while `host_rvalid` is 1 |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| ovr_flag | output | 1 | Sticky access-past-window flag |
| flt_raddr | input | 6 | Filter read address |
| flt_rdata | output | 16 | Filter read data, one cycle after the address |
| flt_taps | output | 7 | Tap count minus one |
| flt_offset | output | 6 | Coefficient offset |
| flt_sym | output | 1 | Symmetric mode |
| flt_cfg_ok | output | 1 | Tap count fits the selected mode |

## Verification
Several properties are checked on every cycle. The overrun flag stays set until a start write and clears right after one. It only rises after a data access. Read strobes always produce a valid cycle. The filter-side settings move only on their own writes, and symmetric mode always reports a legal configuration. Other behaviour is shown only by the bench scenarios: the order in which window addresses are visited, the exact stop point, the low-byte-first assembly in byte mode and the dropping of a half pair on reload. These scenarios check memory contents through the filter read port.

// File: rtl/coefwin_pkg.sv
// Shared constants and codes for the coefficient window port.
// Assumes a 16-bit coefficient word carried as two bytes in byte mode.
package coefwin_pkg;
    localparam int CW_DEPTH = 64;
    localparam int CW_DW    = 16;
    localparam int CW_TW    = 7;
    localparam int CW_SELW  = 3;

    typedef enum logic [2:0] {
        SEL_TAPS  = 3'd0,
        SEL_OFFS  = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_START = 3'd3,
        SEL_STOP  = 3'd4,
        SEL_DATA  = 3'd5
    } sel_e;

    typedef enum logic [2:0] {
        RS_NONE = 3'd0,
        RS_REG  = 3'd1,
        RS_WORD = 3'd2,
        RS_LO   = 3'd3,
        RS_HI   = 3'd4
    } rsrc_e;
endpackage

// File: rtl/coef_cfg_regs.sv
// Setting registers: taps, offset, symmetric bit, window start and stop.
// Produces a combinational readback value for the selected register.
// Assumes the caller gates wr_en with the host write strobe.
module coef_cfg_regs
    import coefwin_pkg::*;
#(
    parameter int DW = CW_DW,
    parameter int AW = 6,
    parameter int TW = CW_TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [TW-1:0] taps,
    output logic [AW-1:0] offs,
    output logic          sym,
    output logic [AW-1:0] start,
    output logic [AW-1:0] stop,
    output logic [DW-1:0] rb_val
);
    // Register writes, decoded by select code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps  <= '0;
            offs  <= '0;
            sym   <= 1'b0;
            start <= '0;
            stop  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_TAPS:  taps  <= wdata[TW-1:0];
                SEL_OFFS:  offs  <= wdata[AW-1:0];
                SEL_CTRL:  sym   <= wdata[0];
                SEL_START: start <= wdata[AW-1:0];
                SEL_STOP:  stop  <= wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    // Zero-extended readback of the selected register.
    always_comb begin
        case (sel)
            SEL_TAPS:  rb_val = DW'(taps);
            SEL_OFFS:  rb_val = DW'(offs);
            SEL_CTRL:  rb_val = DW'(sym);
            SEL_START: rb_val = DW'(start);
            SEL_STOP:  rb_val = DW'(stop);
            default:   rb_val = '0;
        endcase
    end
endmodule

// File: rtl/coef_addr_seq.sv
// Window pointer, byte-pair assembly and overrun tracking.
// Assumes acc_wr and acc_rd are never high together, that byte_mode is
// static during a window, and that a read pair is not mixed with writes.
module coef_addr_seq
    import coefwin_pkg::*;
#(
    parameter int DW = CW_DW,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_mode,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic [AW-1:0] stop_val,
    input  logic [DW-1:0] wdata,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output rsrc_e         rsrc_nx,
    output logic          ovr
);
    localparam int BW = DW / 2;

    logic [AW-1:0] ptr_q;
    logic          done_q;
    logic          half_q;
    logic [BW-1:0] lo_q;
    logic          live;
    logic          step;

    assign live      = (acc_wr || acc_rd) && !done_q;
    assign ram_addr  = ptr_q;
    assign ram_wdata = byte_mode ? {wdata[BW-1:0], lo_q} : wdata;

    // Decide memory strobes, pointer step and read-data source.
    always_comb begin
        ram_we  = 1'b0;
        ram_re  = 1'b0;
        step    = 1'b0;
        rsrc_nx = RS_NONE;
        if (live) begin
            if (acc_wr) begin
                if (!byte_mode || half_q) begin
                    ram_we = 1'b1;
                    step   = 1'b1;
                end
            end else if (!byte_mode) begin
                ram_re  = 1'b1;
                step    = 1'b1;
                rsrc_nx = RS_WORD;
            end else if (!half_q) begin
                ram_re  = 1'b1;
                rsrc_nx = RS_LO;
            end else begin
                step    = 1'b1;
                rsrc_nx = RS_HI;
            end
        end
    end

    // Pointer, window end, byte phase and overrun state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
            half_q <= 1'b0;
            lo_q   <= '0;
            ovr    <= 1'b0;
        end else if (load) begin
            ptr_q  <= load_val;
            done_q <= 1'b0;
            half_q <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if ((acc_wr || acc_rd) && done_q)
                ovr <= 1'b1;
            if (live && byte_mode)
                half_q <= !half_q;
            if (live && acc_wr && byte_mode && !half_q)
                lo_q <= wdata[BW-1:0];
            if (step) begin
                if (ptr_q == stop_val)
                    done_q <= 1'b1;
                else
                    ptr_q <= ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/coef_ram.sv
// Coefficient store: one host write/read port, one filter read port.
// Both reads are registered; contents clear on reset.
module coef_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rq,
    input  logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_rq
);
    logic [DW-1:0] mem [DEPTH];

    // Storage update and host-side read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rq <= '0;
        end else begin
            if (we) mem[addr] <= wdata;
            if (re) rq <= mem[addr];
        end
    end

    // Filter-side read register.
    always_ff @(posedge clk) begin
        if (!rst_n) f_rq <= '0;
        else        f_rq <= mem[f_addr];
    end
endmodule

// File: rtl/coef_window_port.sv
// Top: host register port onto the coefficient store, plus filter taps.
// Assumes host memory traffic only while the filter is idle.
module coef_window_port
    import coefwin_pkg::*;
#(
    parameter int DEPTH = CW_DEPTH,
    parameter int DW    = CW_DW,
    parameter int TW    = CW_TW,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_mode,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [2:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic          ovr_flag,
    input  logic [AW-1:0] flt_raddr,
    output logic [DW-1:0] flt_rdata,
    output logic [TW-1:0] flt_taps,
    output logic [AW-1:0] flt_offset,
    output logic          flt_sym,
    output logic          flt_cfg_ok
);
    localparam int BW = DW / 2;

    logic          rd_only, acc_wr, acc_rd, load;
    logic [AW-1:0] start_v, stop_v, ram_addr;
    logic [DW-1:0] rb_val, ram_wdata, ram_q, reg_q;
    logic          ram_we, ram_re;
    rsrc_e         rsrc_nx, rsrc_q;

    assign rd_only = host_rd && !host_wr;
    assign acc_wr  = host_wr && (host_sel == SEL_DATA);
    assign acc_rd  = rd_only && (host_sel == SEL_DATA);
    assign load    = host_wr && (host_sel == SEL_START);

    coef_cfg_regs #(.DW(DW), .AW(AW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .sel(host_sel),
        .wdata(host_wdata), .taps(flt_taps), .offs(flt_offset),
        .sym(flt_sym), .start(start_v), .stop(stop_v), .rb_val(rb_val)
    );

    coef_addr_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .load(load),
        .load_val(host_wdata[AW-1:0]), .stop_val(stop_v),
        .wdata(host_wdata), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .rsrc_nx(rsrc_nx), .ovr(ovr_flag)
    );

    coef_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .re(ram_re),
        .addr(ram_addr), .wdata(ram_wdata), .rq(ram_q),
        .f_addr(flt_raddr), .f_rq(flt_rdata)
    );

    // Asymmetric mode allows at most DEPTH taps.
    assign flt_cfg_ok = flt_sym || (flt_taps < TW'(DEPTH));

    // Capture read validity, source and register value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            rsrc_q      <= RS_NONE;
            reg_q       <= '0;
        end else begin
            host_rvalid <= rd_only;
            reg_q       <= rb_val;
            if (!rd_only)                    rsrc_q <= RS_NONE;
            else if (host_sel == SEL_DATA)   rsrc_q <= rsrc_nx;
            else                             rsrc_q <= RS_REG;
        end
    end

    // Steer read data from the captured source.
    always_comb begin
        case (rsrc_q)
            RS_REG:  host_rdata = reg_q;
            RS_WORD: host_rdata = ram_q;
            RS_LO:   host_rdata = DW'(ram_q[BW-1:0]);
            RS_HI:   host_rdata = DW'(ram_q[DW-1:BW]);
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/coef_window_chk.sv
// Cycle-level checks on the coefficient window port, bound to its top.
module coef_window_chk #(
    parameter int AW = 6,
    parameter int TW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          host_rd,
    input logic [2:0]    host_sel,
    input logic          host_rvalid,
    input logic          ovr_flag,
    input logic [TW-1:0] flt_taps,
    input logic [AW-1:0] flt_offset,
    input logic          flt_sym,
    input logic          flt_cfg_ok
);
    p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid);
    p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(host_wr && host_sel == 3'd3)) |=> ovr_flag);
    p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(host_wr || host_rd) && $past(host_sel) == 3'd5));
    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 3'd3) |=> !ovr_flag);
    p_taps_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel == 3'd0) |=> $stable(flt_taps));
    p_offs_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel == 3'd1) |=> $stable(flt_offset));
    p_sym_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_sym |-> flt_cfg_ok);
endmodule

bind coef_window_port coef_window_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_rvalid(host_rvalid), .ovr_flag(ovr_flag),
    .flt_taps(flt_taps), .flt_offset(flt_offset), .flt_sym(flt_sym),
    .flt_cfg_ok(flt_cfg_ok)
);

// File: tb/coef_window_port_bench.sv
module coef_window_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;
    // Vector: {rd, sel[2:0], data[15:0], requirement[7:0]}
    localparam logic [27:0] VEC [NV] = '{
        28'h0_0045_02, 28'h8_0045_02,   // R2 taps
        28'h1_002d_02, 28'h9_002d_02,   // R2 offset
        28'h2_0001_02, 28'ha_0001_02,   // R2 control
        28'h4_0005_02, 28'h3_0003_02,   // stop 5, start 3
        28'hb_0003_02, 28'hc_0005_02,   // R2 start/stop readback
        28'h5_a111_03, 28'h5_b222_03, 28'h5_c333_03, // R3 writes 3..5
        28'h3_0003_09,                  // R9 reload
        28'hd_a111_04, 28'hd_b222_04, 28'hd_c333_04, // R4 reads
        28'hd_0000_06                   // R6 past window
    };

    logic        clk = 0, rst_n = 0, byte_mode = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [2:0]  host_sel = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata, flt_rdata;
    logic        host_rvalid, ovr_flag, flt_sym, flt_cfg_ok;
    logic [5:0]  flt_raddr = 0, flt_offset;
    logic [6:0]  flt_taps;
    int          total = 0, bad = 0;
    logic [15:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_window_port u_coef_window_port (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .ovr_flag(ovr_flag),
        .flt_raddr(flt_raddr), .flt_rdata(flt_rdata),
        .flt_taps(flt_taps), .flt_offset(flt_offset),
        .flt_sym(flt_sym), .flt_cfg_ok(flt_cfg_ok)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1; host_sel = s;
        @(negedge clk);
        host_rd = 0;
        d = host_rvalid ? host_rdata : 16'hxxxx;
    endtask

    task automatic fread(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        flt_raddr = a;
        @(negedge clk);
        d = flt_rdata;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rvalid", {15'd0, host_rvalid}, 16'd0);
        chk("R1 ovr", {15'd0, ovr_flag}, 16'd0);
        chk("R1 taps", {9'd0, flt_taps}, 16'd0);
        chk("R1 sym", {15'd0, flt_sym}, 16'd0);
        fread(6'd7, got); chk("R1 mem", got, 16'h0000);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) begin
                rd(VEC[i][26:24], got);
                chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), got, VEC[i][23:8]);
            end else begin
                wr(VEC[i][26:24], VEC[i][23:8]);
            end
        end

        // R6: flag set, ignored write leaves next location untouched
        @(negedge clk); chk("R6 ovr", {15'd0, ovr_flag}, 16'd1);
        wr(3'd5, 16'h9999);
        fread(6'd6, got); chk("R6 no write", got, 16'h0000);
        fread(6'd5, got); chk("R6 stop kept", got, 16'hc333);
        fread(6'd4, got); chk("R3 addr4", got, 16'hb222);
        // R10: filter-side settings
        chk("R10 taps", {9'd0, flt_taps}, 16'h0045);
        chk("R10 offset", {10'd0, flt_offset}, 16'h002d);
        chk("R10 sym", {15'd0, flt_sym}, 16'd1);
        chk("R11 sym ok", {15'd0, flt_cfg_ok}, 16'd1);
        // R9: start write clears flag
        wr(3'd3, 16'd0);
        chk("R9 ovr clear", {15'd0, ovr_flag}, 16'd0);

        // R5: single location window
        wr(3'd4, 16'd10); wr(3'd3, 16'd10);
        wr(3'd5, 16'h1234); wr(3'd5, 16'h5678);
        fread(6'd10, got); chk("R5 one write", got, 16'h1234);
        fread(6'd11, got); chk("R5 no spill", got, 16'h0000);
        chk("R5 ovr", {15'd0, ovr_flag}, 16'd1);

        // R7: byte-mode write assembly
        byte_mode = 1;
        wr(3'd4, 16'd21); wr(3'd3, 16'd20);
        wr(3'd5, 16'h0034);
        fread(6'd20, got); chk("R7 not yet", got, 16'h0000);
        wr(3'd5, 16'h0012);
        fread(6'd20, got); chk("R7 word20", got, 16'h1234);
        wr(3'd5, 16'h00cd); wr(3'd5, 16'h00ab);
        fread(6'd21, got); chk("R7 word21", got, 16'habcd);

        // R9: reload drops a held low byte
        wr(3'd4, 16'd31); wr(3'd3, 16'd30);
        wr(3'd5, 16'h0077);
        wr(3'd3, 16'd30);
        wr(3'd5, 16'h0022); wr(3'd5, 16'h0011);
        fread(6'd30, got); chk("R9 discard", got, 16'h1122);

        // R8: byte-mode reads low then high
        wr(3'd3, 16'd20);
        rd(3'd5, got); chk("R8 lo20", got, 16'h0034);
        rd(3'd5, got); chk("R8 hi20", got, 16'h0012);
        rd(3'd5, got); chk("R8 lo21", got, 16'h00cd);
        rd(3'd5, got); chk("R8 hi21", got, 16'h00ab);

        // R11: tap limit in asymmetric mode
        byte_mode = 0;
        wr(3'd2, 16'd0); wr(3'd0, 16'd64);
        chk("R11 too many", {15'd0, flt_cfg_ok}, 16'd0);
        wr(3'd0, 16'd63);
        chk("R11 at limit", {15'd0, flt_cfg_ok}, 16'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule